// File: doc/BRIEF.md
# Even/Odd Karatsuba-Style GF(2^m) Multiplier

This block multiplies two elements of GF(2^M) in polynomial basis. The field polynomial is the trinomial x^M + x^L + 1. Each operand is split into two halves: the coefficients at even positions and the coefficients at odd positions. This gives A = AL(x)^2 + x*AH(x)^2, and B splits the same way.

Three half-width products are computed in parallel: AL*BL, AH*BH and (AL+AH)*(BL+BH). Each runs on its own pipelined digit-serial array of K processing elements. Each element takes one D-bit digit of the A-side half. The A-side half is fed in groups of K*D bits, highest group first, into a shift-accumulator that is not reduced. Two final stages then square the three products, weight them by (1+x), (x+x^2) and x, XOR them together and fold the sum below degree M.

Operands enter on a valid/ready handshake, and the result leaves on a second one. The block holds one operation at a time. in_ready is high only when no operation is in flight. A result stays on the output with out_valid high until out_ready takes it. Back-pressure on the output therefore stalls the input side.

Top module: `gfk_mul`

## Requirements
- R1: When out_valid is high, result equals A*B mod (x^M + x^M... reduced by x^M + x^L + 1) for the operands accepted last, with bit i of every M-bit word being the coefficient of x^i (defaults M=17, L=3).
- R2: Operands whose set bits lie only at even positions, or only at odd positions, give the correct field product.
- R3: out_valid first reads high NG+K+2 rising edges after the accepting edge, where H=ceil(M/2), K is the smallest integer with 2*D*K*K >= M, and NG=ceil(H/(K*D)). With the defaults D=2, K=3 and NG=2, this is 7 edges.
- R4: While an operation is in flight, in_ready is low and in_valid together with the a and b values has no effect on the result produced.
- R5: While out_valid is high and out_ready is low, out_valid stays high and result does not change.
- R6: After reset, in_ready is high and out_valid is low.
- R7: A zero operand gives a zero product, and the operand 1 returns the other operand unchanged.
- R8: Products whose unreduced degree is near 2M-2 come out fully reduced, for example all-ones squared and x^(M-1) squared.
- R9: On the edge where out_valid and out_ready are both high, the result is consumed: out_valid falls and in_ready rises, so a new operation can be accepted on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle, operands will be taken |
| a | input | M | Multiplicand, bit i = coefficient of x^i |
| b | input | M | Multiplier, bit i = coefficient of x^i |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| result | output | M | Reduced product |

## Verification
The bench targets even-only and odd-only operands. If the two halves were swapped or misaligned, these give wrong products instead of merely scrambled ones. It also targets all-ones and x^(M-1) squared. These drive the unreduced sum up to its top bits, where a single fold pass would leave bits at or above degree M. Offered operands are changed while busy to catch a block that recaptures its inputs. The output is held under back-pressure to catch a result that moves or a valid flag that drops. The arrival edge is counted exactly, which exposes any extra or missing pipeline stage.

// File: rtl/gfk_pkg.sv
package gfk_pkg;
  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  // smallest k with 2*d*k*k >= m
  function automatic int ksize(input int m, input int d);
    int k;
    k = 1;
    while (2 * d * k * k < m) k++;
    return k;
  endfunction
endpackage

// File: rtl/gfk_split.sv
module gfk_split #(
  parameter int M = 17,
  parameter int H = (M + 1) / 2
) (
  input  logic [M-1:0] x,
  output logic [H-1:0] ev,
  output logic [H-1:0] od,
  output logic [H-1:0] sm
);
  logic [2*H-1:0] xp;
  assign xp = (2*H)'(x);

  for (genvar i = 0; i < H; i++) begin : g_bit
    assign ev[i] = xp[2*i];
    assign od[i] = xp[2*i+1];
  end

  assign sm = ev ^ od;
endmodule

// File: rtl/gfk_array.sv
module gfk_array #(
  parameter int H  = 9,
  parameter int D  = 2,
  parameter int K  = 3,
  parameter int NG = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [H-1:0]   bop,
  input  logic [K*D-1:0] grp_in,
  input  logic           v_in,
  input  logic           last_in,
  output logic [2*H-2:0] prod,
  output logic           done
);
  localparam int G  = K * D;
  localparam int PW = H + G - 1;
  localparam int AW = NG * G + H - 1;
  localparam int PL = 2 * H - 1;

  for (genvar s = 0; s < K; s++) begin : stg
    logic [PW-1:0] sum_i, term, sum_q;
    logic [G-1:0]  grp_i, grp_q;
    logic          v_i, l_i, v_q, l_q;

    if (s == 0) begin : g_head
      assign sum_i = '0;
      assign grp_i = grp_in;
      assign v_i   = v_in;
      assign l_i   = last_in;
    end else begin : g_link
      assign sum_i = stg[s-1].sum_q;
      assign grp_i = stg[s-1].grp_q;
      assign v_i   = stg[s-1].v_q;
      assign l_i   = stg[s-1].l_q;
    end

    always_comb begin
      term = '0;
      for (int i = 0; i < D; i++)
        if (grp_i[s*D+i]) term = term ^ (PW'(bop) << (s*D + i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        l_q   <= 1'b0;
        sum_q <= '0;
        grp_q <= '0;
      end else begin
        v_q   <= v_i;
        l_q   <= v_i & l_i;
        sum_q <= sum_i ^ term;
        grp_q <= grp_i;
      end
    end
  end

  logic [AW-1:0] acc;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= stg[K-1].l_q;
      if (clr) acc <= '0;
      else if (stg[K-1].v_q) acc <= (acc << G) ^ AW'(stg[K-1].sum_q);
    end
  end

  assign prod = acc[PL-1:0];
  assign done = done_q;

  a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    stg[K-1].l_q |-> stg[K-1].v_q);

  if (AW > PL) begin : g_fit
    a_r1_acc_fits: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (acc[AW-1:PL] == '0));
  end
endmodule

// File: rtl/gfk_post.sv
module gfk_post #(
  parameter int M = 17,
  parameter int L = 3,
  parameter int H = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [2*H-2:0] p0,
  input  logic [2*H-2:0] p1,
  input  logic [2*H-2:0] p2,
  output logic           load,
  output logic [M-1:0]   res
);
  localparam int W = 4 * H - 1;

  logic [W-1:0] s0, s1, s2, comb_c, c1_q, fold_t;
  logic         v1_q;
  logic [M-1:0] res_q;

  always_comb begin
    s0 = '0;
    s1 = '0;
    s2 = '0;
    for (int i = 0; i < 2*H-1; i++) begin
      s0[2*i] = p0[i];
      s1[2*i] = p1[i];
      s2[2*i] = p2[i];
    end
    comb_c = s0 ^ (s0 << 1) ^ (s1 << 1) ^ (s1 << 2) ^ (s2 << 1);
  end

  always_comb begin
    fold_t = c1_q;
    for (int i = W - 1; i >= M; i--) begin
      if (fold_t[i]) begin
        fold_t[i]       = 1'b0;
        fold_t[i-M]     = ~fold_t[i-M];
        fold_t[i-M+L]   = ~fold_t[i-M+L];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      c1_q  <= '0;
      res_q <= '0;
    end else begin
      v1_q <= go;
      if (go) c1_q <= comb_c;
      if (v1_q) res_q <= fold_t[M-1:0];
    end
  end

  assign load = v1_q;
  assign res  = res_q;

  a_r8_fold_clean: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> (res == $past(fold_t[M-1:0])) && (v1_q == $past(go)));
endmodule

// File: rtl/gfk_mul.sv
module gfk_mul #(
  parameter int M = 17,
  parameter int L = 3,
  parameter int D = 2,
  parameter int K = gfk_pkg::ksize(M, D)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] result
);
  localparam int H   = (M + 1) / 2;
  localparam int G   = K * D;
  localparam int NG  = gfk_pkg::cdiv(H, G);
  localparam int FW  = (NG > 1) ? $clog2(NG) : 1;
  localparam int LAT = NG + K + 2;

  logic [H-1:0] al, ah, as, bl, bh, bs;
  logic [H-1:0] al_q, ah_q, as_q, bl_q, bh_q, bs_q;
  logic         busy, feeding, ov;
  logic [FW-1:0] fc;
  logic         accept;

  gfk_split #(.M(M), .H(H)) u_sa (.x(a), .ev(al), .od(ah), .sm(as));
  gfk_split #(.M(M), .H(H)) u_sb (.x(b), .ev(bl), .od(bh), .sm(bs));

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;

  // group selection: most significant group first
  logic [FW-1:0] gi;
  logic          last_g;
  logic [NG*G-1:0] pa0, pa1, pa2;
  logic [G-1:0]  g0, g1, g2;

  assign gi     = FW'(NG - 1) - fc;
  assign last_g = (fc == FW'(NG - 1));
  assign pa0 = (NG*G)'(al_q);
  assign pa1 = (NG*G)'(ah_q);
  assign pa2 = (NG*G)'(as_q);
  assign g0  = pa0[gi*G +: G];
  assign g1  = pa1[gi*G +: G];
  assign g2  = pa2[gi*G +: G];

  logic [2*H-2:0] p0, p1, p2;
  logic           d0, d1, d2;
  logic           load;

  gfk_array #(.H(H), .D(D), .K(K), .NG(NG)) u_arr0 (
    .clk(clk), .rst_n(rst_n), .clr(accept), .bop(bl_q), .grp_in(g0),
    .v_in(feeding), .last_in(last_g), .prod(p0), .done(d0));
  gfk_array #(.H(H), .D(D), .K(K), .NG(NG)) u_arr1 (
    .clk(clk), .rst_n(rst_n), .clr(accept), .bop(bh_q), .grp_in(g1),
    .v_in(feeding), .last_in(last_g), .prod(p1), .done(d1));
  gfk_array #(.H(H), .D(D), .K(K), .NG(NG)) u_arr2 (
    .clk(clk), .rst_n(rst_n), .clr(accept), .bop(bs_q), .grp_in(g2),
    .v_in(feeding), .last_in(last_g), .prod(p2), .done(d2));

  gfk_post #(.M(M), .L(L), .H(H)) u_post (
    .clk(clk), .rst_n(rst_n), .go(d0), .p0(p0), .p1(p1), .p2(p2),
    .load(load), .res(result));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      feeding <= 1'b0;
      ov      <= 1'b0;
      fc      <= '0;
      {al_q, ah_q, as_q, bl_q, bh_q, bs_q} <= '0;
    end else begin
      if (accept) begin
        busy    <= 1'b1;
        feeding <= 1'b1;
        fc      <= '0;
        al_q <= al; ah_q <= ah; as_q <= as;
        bl_q <= bl; bh_q <= bh; bs_q <= bs;
      end else if (feeding) begin
        fc <= fc + 1'b1;
        if (last_g) feeding <= 1'b0;
      end
      if (load) ov <= 1'b1;
      else if (ov && out_ready) begin
        ov   <= 1'b0;
        busy <= 1'b0;
      end
    end
  end

  assign out_valid = ov;

  // latency tracker used by the assertions only
  logic [15:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy && !ov) lat_cnt <= lat_cnt + 1'b1;
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 16'(LAT)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  a_r4_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> ($stable(al_q) && $stable(bh_q)));

  a_r3_arrays_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    d0 |-> (d1 && d2));
endmodule

// File: tb/tb_gfk_mul.sv
module tb_gfk_mul;
  localparam int M   = 17;
  localparam int L   = 3;
  localparam int LAT = 7; // R3 with D=2: K=3, NG=2 -> 2+3+2

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [M-1:0] a = '0, b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [M-1:0] result;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  gfk_mul dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .out_valid(out_valid), .out_ready(out_ready),
    .result(result));

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] r;
    logic msb;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      msb = r[M-1];
      r = r << 1;
      if (msb) r = r ^ (M'(1) | (M'(1) << L));
      if (x[i]) r = r ^ y;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [M-1:0] x, input logic [M-1:0] y,
                        input int hold, input bit junk, input string tag);
    logic [M-1:0] exp;
    int n;
    exp = ref_mul(x, y);
    @(negedge clk);
    in_valid = 1'b1; a = x; b = y;
    check(in_ready == 1'b1, "R9 ready before accept", in_ready, 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R4 busy drops ready", in_ready, 0);
    if (junk) begin
      in_valid = 1'b1; a = ~x; b = y ^ M'(5);
    end
    n = 0;
    while (!out_valid && n < 50) begin
      @(posedge clk); #1;
      n++;
    end
    check(n == LAT, "R3 latency", n, LAT);
    check(result == exp, tag, result, exp);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); #1;
      check(out_valid && result == exp, "R5 held", result, exp);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R9 consumed", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    #1500000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [M-1:0] all1, ev, od, top;
    void'($urandom(32'h5eed_1234));
    all1 = '1;
    ev = '0;
    od = '0;
    for (int i = 0; i < M; i++) if (i % 2 == 0) ev[i] = 1'b1; else od[i] = 1'b1;
    top = M'(1) << (M - 1);

    repeat (3) @(posedge clk);
    #1;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R6 reset", {in_ready, out_valid}, 2'b10);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R6 after release", {in_ready, out_valid}, 2'b10);

    run_op('0, 17'h1abcd, 0, 0, "R7 zero");
    run_op(M'(1), 17'h0f0f3, 1, 0, "R7 one");
    run_op(all1, all1, 2, 1, "R8 all ones squared");
    run_op(top, top, 0, 0, "R8 top squared");
    run_op(top, all1, 3, 1, "R8 top times ones");
    run_op(ev, ev, 0, 0, "R2 even only");
    run_op(od, od, 1, 0, "R2 odd only");
    run_op(ev, od, 0, 1, "R2 even times odd");
    run_op(M'(2), top, 0, 0, "R8 wraps once");

    for (int t = 0; t < 150; t++) begin
      logic [M-1:0] x, y;
      x = M'($urandom);
      y = M'($urandom);
      run_op(x, y, int'($urandom % 4), bit'($urandom % 2), "R1 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule